// File: doc/BRIEF.md
# Early Load Queue Invalidation Unit

This block holds a small set of early-load entries. Each entry records its base register, its computed memory address and the data fetched for it, plus a valid flag and a started flag. An entry is created with valid set and started clear. The cache access itself sits outside the block. When the access is requested, a base-register-busy indication from the register status table decides whether it may begin. If the register is still being computed, the entry is dropped before any access is made.

After an entry has started, two searches watch for hazards, and both run against every entry in the same cycle. The first is a decode search. An instruction leaving decode whose destination register equals a started entry's base register invalidates that entry. The second is a store search. A store whose word address equals a started entry's word address also invalidates it. An invalidated entry never supplies data, and the load then takes the normal execute/memory path. Returned data is written through a fill port, and a read port shows the valid flag, the started flag and the data of any one entry.

Top module: `early_load_inval_unit`

## Requirements
- R1: Synchronous reset clears every entry, so each index then reads rd_valid=0, rd_started=0 and rd_data=0.
- R2: An allocate to an index makes that entry valid, not started, with data 0, holding the given base register and address. An entry becomes valid only through an allocate.
- R3: A start request with start_base_busy=0 on an entry that is valid and not started sets its started flag in the next cycle. A start request on an invalid entry has no effect.
- R4: A start request with start_base_busy=1 on an entry that is valid and not started clears its valid flag, and its started flag stays 0.
- R5: A decode with destination register equal to the base register of a valid started entry invalidates that entry in the next cycle. All matching entries are invalidated in the same cycle. Entries that have not started are unaffected.
- R6: A store address that matches the address of a valid started entry in bits [ADDR_W-1:2] invalidates that entry in the next cycle. The two byte-offset bits [1:0] are ignored, and entries that have not started are unaffected.
- R7: A decode search and a store search in the same cycle each invalidate their own matching entries.
- R8: A fill to a valid started entry writes its data, which is readable in the next cycle. A fill to an invalid or unstarted entry leaves the data unchanged.
- R9: When an entry is invalidated in the same cycle as a fill to it, the invalidation wins and the data is not written.
- R10: A deallocate clears the entry (valid, started and data all 0). If deallocate and allocate name the same index in the same cycle, deallocate wins.
- R11: rd_data reads 0 whenever the addressed entry is not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_en | input | 1 | Allocate an entry |
| alloc_idx | input | 4 | Index of the entry to allocate |
| alloc_base | input | 4 | Base register of the new entry |
| alloc_addr | input | 32 | Computed memory address of the new entry |
| dealloc_en | input | 1 | Free an entry |
| dealloc_idx | input | 4 | Index of the entry to free |
| start_en | input | 1 | Request to begin the early access of an entry |
| start_idx | input | 4 | Index of the entry to start |
| start_base_busy | input | 1 | Base register still busy, from the status table |
| fill_en | input | 1 | Fetched data returning |
| fill_idx | input | 4 | Entry receiving data |
| fill_data | input | 32 | Fetched data |
| dec_en | input | 1 | An instruction passes decode |
| dec_dest | input | 4 | Its destination register |
| st_en | input | 1 | A store address was produced |
| st_addr | input | 32 | The store byte address |
| rd_idx | input | 4 | Entry to read |
| rd_valid | output | 1 | Valid flag of the read entry |
| rd_started | output | 1 | Started flag of the read entry |
| rd_data | output | 32 | Data of the read entry, 0 when invalid |

## Verification
Each entry's flags can be seen directly at the read port one cycle after the event that changes them. A wrong match width or a wrong priority therefore shows up as a wrong valid bit or stale data at the very next read of that index. The bench sweeps every index after every event. This catches a missed invalidation, an invalidation of a neighbour or an unstarted entry, or a fill that leaked through on the first cycle it happens. Sweeps over all destination registers and over offset bits in store addresses show comparators that use too many or too few bits.

// File: rtl/elq_pkg.sv
package elq_pkg;
    parameter int NUM_ENTRIES = 16;
    parameter int REG_W       = 4;
    parameter int ADDR_W      = 32;
    parameter int DATA_W      = 32;
    parameter int OFS_W       = 2;
    localparam int IDX_W      = $clog2(NUM_ENTRIES);

    typedef struct packed {
        logic              valid;
        logic              started;
        logic [REG_W-1:0]  base;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } elq_entry_t;

    // word-granular address equality, byte offset ignored
    function automatic logic same_word(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] b);
        return ((a ^ b) >> OFS_W) == '0;
    endfunction
endpackage

// File: rtl/elq_hazard_match.sv
module elq_hazard_match
    import elq_pkg::*;
(
    input  logic              ent_valid,
    input  logic              ent_started,
    input  logic [REG_W-1:0]  ent_base,
    input  logic [ADDR_W-1:0] ent_addr,
    input  logic              dec_en,
    input  logic [REG_W-1:0]  dec_dest,
    input  logic              st_en,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              dec_hit,
    output logic              st_hit,
    output logic              kill
);
    logic armed;

    always_comb begin
        armed   = ent_valid & ent_started;
        dec_hit = armed & dec_en & (dec_dest == ent_base);
        st_hit  = armed & st_en & same_word(st_addr, ent_addr);
        kill    = dec_hit | st_hit;
    end
endmodule

// File: rtl/elq_entry.sv
module elq_entry
    import elq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_hit,
    input  logic [REG_W-1:0]  alloc_base,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              dealloc_hit,
    input  logic              start_hit,
    input  logic              start_busy,
    input  logic              fill_hit,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              kill,
    output elq_entry_t        q
);
    always_ff @(posedge clk) begin
        if (rst || dealloc_hit) begin
            q <= '0;
        end else if (alloc_hit) begin
            q.valid   <= 1'b1;
            q.started <= 1'b0;
            q.base    <= alloc_base;
            q.addr    <= alloc_addr;
            q.data    <= '0;
        end else begin
            if (start_hit && q.valid && !q.started) begin
                if (start_busy) q.valid   <= 1'b0;
                else            q.started <= 1'b1;
            end
            if (kill)
                q.valid <= 1'b0;
            else if (fill_hit && q.valid && q.started)
                q.data <= fill_data;
        end
    end

    p_valid_from_alloc_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(q.valid) |-> $past(alloc_hit));

    p_start_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (start_hit && !start_busy && q.valid && !q.started && !alloc_hit && !dealloc_hit)
        |=> q.started);

    p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (start_hit && start_busy && q.valid && !q.started && !alloc_hit && !dealloc_hit)
        |=> (!q.valid && !q.started));

    p_kill_drops_r5: assert property (@(posedge clk) disable iff (rst)
        (kill && !alloc_hit && !dealloc_hit) |=> !q.valid);

    p_dead_data_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        ((!(q.valid && q.started) || kill) && !alloc_hit && !dealloc_hit)
        |=> $stable(q.data));

    p_dealloc_clears_r10: assert property (@(posedge clk) disable iff (rst)
        dealloc_hit |=> (q == '0));
endmodule

// File: rtl/early_load_inval_unit.sv
module early_load_inval_unit
    import elq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_en,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [REG_W-1:0]  alloc_base,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              dealloc_en,
    input  logic [IDX_W-1:0]  dealloc_idx,
    input  logic              start_en,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic              start_base_busy,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              dec_en,
    input  logic [REG_W-1:0]  dec_dest,
    input  logic              st_en,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_started,
    output logic [DATA_W-1:0] rd_data
);
    elq_entry_t             ent   [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] kill_v;
    logic [NUM_ENTRIES-1:0] dec_v;
    logic [NUM_ENTRIES-1:0] st_v;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        elq_hazard_match u_match (
            .ent_valid   (ent[g].valid),
            .ent_started (ent[g].started),
            .ent_base    (ent[g].base),
            .ent_addr    (ent[g].addr),
            .dec_en      (dec_en),
            .dec_dest    (dec_dest),
            .st_en       (st_en),
            .st_addr     (st_addr),
            .dec_hit     (dec_v[g]),
            .st_hit      (st_v[g]),
            .kill        (kill_v[g])
        );

        elq_entry u_entry (
            .clk         (clk),
            .rst         (rst),
            .alloc_hit   (alloc_en   && (alloc_idx   == IDX_W'(g))),
            .alloc_base  (alloc_base),
            .alloc_addr  (alloc_addr),
            .dealloc_hit (dealloc_en && (dealloc_idx == IDX_W'(g))),
            .start_hit   (start_en   && (start_idx   == IDX_W'(g))),
            .start_busy  (start_base_busy),
            .fill_hit    (fill_en    && (fill_idx    == IDX_W'(g))),
            .fill_data   (fill_data),
            .kill        (kill_v[g]),
            .q           (ent[g])
        );
    end

    always_comb begin
        rd_valid   = ent[rd_idx].valid;
        rd_started = ent[rd_idx].started;
        rd_data    = ent[rd_idx].valid ? ent[rd_idx].data : '0;
    end

    // the two searches are independent: a store hit never needs a decode hit
    p_search_split_r7: assert property (@(posedge clk) disable iff (rst)
        !dec_en |-> (dec_v == '0));

    p_store_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !st_en |-> (st_v == '0));
endmodule

// File: tb/tb_early_load_inval_unit.sv
`timescale 1ns/1ps
module tb_early_load_inval_unit;
    import elq_pkg::*;
    localparam int NE = NUM_ENTRIES;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alloc_en, dealloc_en, start_en, start_base_busy, fill_en, dec_en, st_en;
    logic [IDX_W-1:0]  alloc_idx, dealloc_idx, start_idx, fill_idx, rd_idx;
    logic [REG_W-1:0]  alloc_base, dec_dest;
    logic [ADDR_W-1:0] alloc_addr, st_addr;
    logic [DATA_W-1:0] fill_data, rd_data;
    logic rd_valid, rd_started;

    logic              m_v [NE];
    logic              m_s [NE];
    logic [REG_W-1:0]  m_b [NE];
    logic [ADDR_W-1:0] m_a [NE];
    logic [DATA_W-1:0] m_d [NE];

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    early_load_inval_unit dut (.*);

    task automatic idle();
        alloc_en = 0; dealloc_en = 0; start_en = 0; start_base_busy = 0;
        fill_en = 0; dec_en = 0; st_en = 0;
        alloc_idx = '0; dealloc_idx = '0; start_idx = '0; fill_idx = '0;
        alloc_base = '0; dec_dest = '0; alloc_addr = '0; st_addr = '0;
        fill_data = '0;
    endtask

    // reference model of the requirements, evaluated on pre-edge state
    task automatic model_step();
        for (int i = 0; i < NE; i++) begin
            logic k;
            k = m_v[i] && m_s[i] &&
                ((dec_en && dec_dest == m_b[i]) ||
                 (st_en && st_addr[ADDR_W-1:2] == m_a[i][ADDR_W-1:2]));
            if (dealloc_en && dealloc_idx == IDX_W'(i)) begin
                m_v[i] = 0; m_s[i] = 0; m_b[i] = '0; m_a[i] = '0; m_d[i] = '0;
            end else if (alloc_en && alloc_idx == IDX_W'(i)) begin
                m_v[i] = 1; m_s[i] = 0; m_b[i] = alloc_base; m_a[i] = alloc_addr; m_d[i] = '0;
            end else begin
                logic fv;
                fv = m_v[i] && m_s[i];
                if (start_en && start_idx == IDX_W'(i) && m_v[i] && !m_s[i]) begin
                    if (start_base_busy) m_v[i] = 0; else m_s[i] = 1;
                end
                if (k) m_v[i] = 0;
                else if (fill_en && fill_idx == IDX_W'(i) && fv) m_d[i] = fill_data;
            end
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < NE; i++) begin
            logic [DATA_W-1:0] ed;
            rd_idx = IDX_W'(i);
            #0.1;
            ed = m_v[i] ? m_d[i] : '0;
            nchk++;
            if (rd_valid !== m_v[i] || rd_started !== m_s[i] || rd_data !== ed) begin
                nfail++;
                $display("FAIL %s entry %0d: actual v=%b s=%b d=%h expected v=%b s=%b d=%h",
                         req, i, rd_valid, rd_started, rd_data, m_v[i], m_s[i], ed);
            end
        end
    endtask

    task automatic alloc(input int i, input int b, input logic [ADDR_W-1:0] a);
        alloc_en = 1; alloc_idx = IDX_W'(i); alloc_base = REG_W'(b); alloc_addr = a;
        tick();
    endtask

    task automatic start(input int i, input logic busy);
        start_en = 1; start_idx = IDX_W'(i); start_base_busy = busy;
        tick();
    endtask

    task automatic fill(input int i, input logic [DATA_W-1:0] d);
        fill_en = 1; fill_idx = IDX_W'(i); fill_data = d;
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end

    initial begin
        idle();
        rd_idx = '0;
        for (int i = 0; i < NE; i++) begin
            m_v[i] = 0; m_s[i] = 0; m_b[i] = '0; m_a[i] = '0; m_d[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        check_all("R1");

        // R2: allocate every slot
        for (int i = 0; i < NE; i++) alloc(i, i, 32'h1000 + i * 16);
        check_all("R2");

        // R3 / R4: even slots start clean, odd slots see a busy base register
        for (int i = 0; i < NE; i++) start(i, i[0]);
        check_all("R3 R4");
        start(1, 1'b0);               // invalid entry: no effect
        check_all("R3");

        // R8: fill everything; odd (invalid) fills are ignored
        for (int i = 0; i < NE; i++) fill(i, 32'hA500_0000 + i);
        check_all("R8");

        // R5: base = i%4, addresses pair up by word; slots 12..15 stay unstarted
        for (int i = 0; i < NE; i++) alloc(i, i % 4, 32'h2000 + (i / 2) * 4 + (i % 2));
        fill(0, 32'h1111_1111);       // unstarted: ignored (R8)
        check_all("R8");
        for (int i = 0; i < 12; i++) start(i, 1'b0);
        for (int i = 0; i < NE; i++) fill(i, 32'hC000_0000 + i);
        check_all("R8");
        dec_en = 1; dec_dest = 4'd2; tick();
        check_all("R5");

        // R6: offset bits ignored; unstarted slots 12,13 unaffected
        st_en = 1; st_addr = 32'h2000 + 3; tick();
        check_all("R6");
        st_en = 1; st_addr = 32'h2000 + 6 * 4 + 1; tick();
        check_all("R6");
        st_en = 1; st_addr = 32'h2000 + 3 * 4 + 2; tick();   // slot 6 gone, 7 hit
        check_all("R6");

        // R7: both searches together
        dec_en = 1; dec_dest = 4'd3; st_en = 1; st_addr = 32'h2000 + 2 * 4; tick();
        check_all("R7");

        // R9 / R11: kill and fill on slot 8 in one cycle
        fill_en = 1; fill_idx = 4'd8; fill_data = 32'hDEAD_BEEF;
        dec_en = 1; dec_dest = 4'd0; tick();
        check_all("R9 R11");

        // R10: deallocate, then allocate and deallocate the same slot together
        dealloc_en = 1; dealloc_idx = 4'd9; tick();
        check_all("R10");
        alloc_en = 1; alloc_idx = 4'd9; alloc_base = 4'd5; alloc_addr = 32'h40;
        dealloc_en = 1; dealloc_idx = 4'd9; tick();
        check_all("R10");

        // R5 sweep: every destination register against started entries with base = i
        for (int i = 0; i < NE; i++) alloc(i, i, 32'h3000 + i * 4);
        for (int i = 0; i < NE; i++) start(i, 1'b0);
        for (int i = 0; i < NE; i++) fill(i, 32'h5A00_0000 + i);
        for (int d = 0; d < (1 << REG_W); d++) begin
            dec_en = 1; dec_dest = REG_W'(d); tick();
            check_all("R5");
        end

        // R6 sweep: each word with each byte offset
        for (int i = 0; i < NE; i++) alloc(i, 0, 32'h4000 + i * 4);
        for (int i = 0; i < NE; i++) start(i, 1'b0);
        for (int w = 0; w < NE; w++) begin
            st_en = 1; st_addr = 32'h4000 + w * 4 + (w % 4); tick();
            check_all("R6");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule